// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps two 64-bit up-counters (a primary time base and an alternate one) and a 32-bit down-counting decrementer, all advancing on a shared tick enable. Software reaches every counter through a single 32-bit access port. A selector picks the register, so each 64-bit counter is seen as two independent 32-bit halves. A run input freezes all three counters without losing their contents. When running resumes, counting continues from the held values.

The decrementer sets a sticky pending flag in two cases: when it steps from zero to all-ones, and when software stores a negative value over a non-negative count. The flag is cleared by an acknowledge input. A rate-load pulse, given whenever the tick source is set up or retuned, parks the decrementer at all-ones so that no exception is left pending. A compatibility view of the low word of the primary time base applies a fixed mask on both read and write.

Top module: `tbdec_unit`

## Requirements
- R1: When `tick_en` and `run_en` are both high and no write hits a counter, that counter advances by one on the clock edge. The primary time base counts up, including the carry from bit 31 into bit 32. Selector 0 reads bits 31:0 and selector 1 reads bits 63:32.
- R2: A write with selector 0 replaces bits 31:0 of the primary time base and leaves bits 63:32 unchanged. A write with selector 1 replaces bits 63:32 and leaves bits 31:0 unchanged.
- R3: The alternate time base uses selectors 2 (low half) and 3 (high half). It has the same read, write and counting behaviour as the primary time base and is independent of it.
- R4: While `run_en` is low, both time bases and the decrementer hold their values even when `tick_en` is high. After `run_en` returns high, they resume from the held values.
- R5: Selector 4 reads and writes the decrementer, which counts down by one on each advancing tick. On a tick at count 0 it becomes 0xFFFFFFFF and sets `dec_irq`.
- R6: A decrementer write whose bit 31 is 1, made while the current count has bit 31 equal to 0, sets `dec_irq` on that edge. Any other write leaves `dec_irq` unchanged.
- R7: After reset, both time bases are 0, the decrementer is 0xFFFFFFFF and `dec_irq` is 0. A `rate_load` pulse sets the decrementer to 0xFFFFFFFF without setting `dec_irq`. This pulse takes priority over a same-cycle write and over a tick.
- R8: Selector 5 is a compatibility view of bits 31:0 of the primary time base, masked with 0x3FFFFF80. A read returns the low word AND the mask. A write stores the write data AND the mask into bits 31:0 and keeps bits 63:32.
- R9: `dec_irq` stays high until a cycle in which `dec_ack` is high. If a new exception event occurs in that same cycle, the flag stays set.
- R10: A write to a counter takes priority over the tick in the same cycle: the written value is stored and the counter is not advanced on that edge.
- R11: Selectors 6 and 7 read as 0, and writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick enable from the rate generator |
| run_en | input | 1 | High lets the counters run, low freezes them |
| acc_sel | input | 3 | Register selector for the access port |
| acc_wr | input | 1 | Write strobe for the selected register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected register (combinational) |
| rate_load | input | 1 | Tick setup pulse, parks the decrementer at all-ones |
| dec_ack | input | 1 | Clears the pending decrementer exception |
| dec_irq | output | 1 | Sticky decrementer exception pending |

## Verification
The properties assume `rst_n` is held low for at least one clock edge before counting starts. They also assume that `acc_wr`, `rate_load` and `dec_ack` are single-cycle strobes driven synchronously to `clk`, and that `acc_sel` only matters while `acc_wr` is high. The stimulus changes every input half a period away from the rising edge and lowers each strobe after one edge. Reads are done by varying `acc_sel` with no strobe active, so a read never disturbs the state the assertions track.

// File: rtl/tbdec_pkg.sv
`timescale 1ns/1ps
package tbdec_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_TB_LO  = 3'd0,
        SEL_TB_HI  = 3'd1,
        SEL_ALT_LO = 3'd2,
        SEL_ALT_HI = 3'd3,
        SEL_DEC    = 3'd4,
        SEL_RTC_LO = 3'd5
    } acc_sel_e;
endpackage

// File: rtl/tbdec_timebase.sv
`timescale 1ns/1ps
module tbdec_timebase #(
    parameter int TB_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [TB_W/2-1:0] wdata,
    output logic [TB_W-1:0]   cnt
);
    localparam int HALF = TB_W / 2;

    typedef struct packed {
        logic [TB_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.cnt[HALF-1:0] = wdata;
        if (wr_hi) st_d.cnt[TB_W-1:HALF] = wdata;
        if (!wr_lo && !wr_hi && adv) st_d.cnt = st_q.cnt + TB_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + TB_W'(1)));

    p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (cnt[TB_W-1:HALF] == $past(cnt[TB_W-1:HALF])));

    p_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (cnt[HALF-1:0] == $past(cnt[HALF-1:0])));

    p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_lo && !wr_hi) |=> $stable(cnt));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wr_lo) |=> (cnt[HALF-1:0] == $past(wdata)));
endmodule

// File: rtl/tbdec_decrementer.sv
`timescale 1ns/1ps
module tbdec_decrementer #(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr,
    input  logic [DEC_W-1:0] wdata,
    input  logic             reload,
    input  logic             ack,
    output logic [DEC_W-1:0] cnt,
    output logic             pend
);
    localparam int MSB = DEC_W - 1;

    typedef struct packed {
        logic [DEC_W-1:0] cnt;
        logic             pend;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       set_evt;

    always_comb begin
        st_d    = st_q;
        set_evt = 1'b0;
        if (reload) begin
            st_d.cnt = '1;
        end else if (wr) begin
            st_d.cnt = wdata;
            set_evt  = wdata[MSB] & ~st_q.cnt[MSB];
        end else if (adv) begin
            st_d.cnt = st_q.cnt - DEC_W'(1);
            set_evt  = (st_q.cnt == '0);
        end
        st_d.pend = set_evt | (st_q.pend & ~ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign pend = st_q.pend;

    p_wrap_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && !reload && cnt == '0) |=> (pend && cnt == '1));

    p_neg_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !reload && wdata[MSB] && !cnt[MSB]) |=> pend);

    p_reload_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !pend) |=> (cnt == '1 && !pend));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !adv && !wr) |=> !pend);
endmodule

// File: rtl/tbdec_unit.sv
`timescale 1ns/1ps
module tbdec_unit
    import tbdec_pkg::*;
#(
    parameter int          HALF_W   = 32,
    parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run_en,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic              acc_wr,
    input  logic [HALF_W-1:0] acc_wdata,
    output logic [HALF_W-1:0] acc_rdata,
    input  logic              rate_load,
    input  logic              dec_ack,
    output logic              dec_irq
);
    localparam int TB_W  = 2 * HALF_W;
    localparam int N_TB  = 2;
    localparam logic [HALF_W-1:0] MASK_W = HALF_W'(RTC_MASK);

    acc_sel_e           sel;
    logic               adv;
    logic [N_TB-1:0]    wr_lo, wr_hi;
    logic [HALF_W-1:0]  wd   [N_TB];
    logic [TB_W-1:0]    tbv  [N_TB];
    logic [HALF_W-1:0]  dec_cnt;
    logic               dec_wr;

    assign sel    = acc_sel_e'(acc_sel);
    assign adv    = tick_en & run_en;
    assign dec_wr = acc_wr && (sel == SEL_DEC);

    genvar gi;
    generate
        for (gi = 0; gi < N_TB; gi++) begin : g_tb
            if (gi == 0) begin : g_primary
                assign wr_lo[gi] = acc_wr && (sel == SEL_TB_LO || sel == SEL_RTC_LO);
                assign wr_hi[gi] = acc_wr && (sel == SEL_TB_HI);
                assign wd[gi]    = (sel == SEL_RTC_LO) ? (acc_wdata & MASK_W) : acc_wdata;
            end else begin : g_alt
                assign wr_lo[gi] = acc_wr && (sel == SEL_ALT_LO);
                assign wr_hi[gi] = acc_wr && (sel == SEL_ALT_HI);
                assign wd[gi]    = acc_wdata;
            end

            tbdec_timebase #(.TB_W(TB_W)) u_tb (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (adv),
                .wr_lo (wr_lo[gi]),
                .wr_hi (wr_hi[gi]),
                .wdata (wd[gi]),
                .cnt   (tbv[gi])
            );
        end
    endgenerate

    tbdec_decrementer #(.DEC_W(HALF_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .wr     (dec_wr),
        .wdata  (acc_wdata),
        .reload (rate_load),
        .ack    (dec_ack),
        .cnt    (dec_cnt),
        .pend   (dec_irq)
    );

    always_comb begin
        case (sel)
            SEL_TB_LO:  acc_rdata = tbv[0][HALF_W-1:0];
            SEL_TB_HI:  acc_rdata = tbv[0][TB_W-1:HALF_W];
            SEL_ALT_LO: acc_rdata = tbv[1][HALF_W-1:0];
            SEL_ALT_HI: acc_rdata = tbv[1][TB_W-1:HALF_W];
            SEL_DEC:    acc_rdata = dec_cnt;
            SEL_RTC_LO: acc_rdata = tbv[0][HALF_W-1:0] & MASK_W;
            default:    acc_rdata = '0;
        endcase
    end

    p_alt_lockstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr) |=> (tbv[0] - tbv[1] == $past(tbv[0] - tbv[1])));

    p_rtc_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == 3'd5) |-> ((acc_rdata & ~MASK_W) == '0));

    p_dec_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !acc_wr && !rate_load) |=> $stable(dec_cnt));

    p_bad_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel > 3'd5) |-> (acc_rdata == '0));
endmodule

// File: tb/tb_tbdec_unit.sv
`timescale 1ns/1ps
module tb_tbdec_unit;
    localparam logic [31:0] MASK = 32'h3FFF_FF80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, run_en = 1'b0;
    logic [2:0]  acc_sel = 3'd0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        rate_load = 1'b0, dec_ack = 1'b0;
    logic        dec_irq;

    int n_chk = 0, n_fail = 0;

    logic [63:0] m_tb, m_atb;
    logic [31:0] m_dec;
    logic        m_pend;

    always #2 clk = ~clk;

    tbdec_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .rate_load(rate_load), .dec_ack(dec_ack),
        .dec_irq(dec_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        acc_sel = s;
        #0.1;
        v = acc_rdata;
    endtask

    task automatic read_all(input string tag);
        logic [31:0] v;
        rd(3'd0, v); chk(tag, v, m_tb[31:0]);
        rd(3'd1, v); chk(tag, v, m_tb[63:32]);
        rd(3'd2, v); chk(tag, v, m_atb[31:0]);
        rd(3'd3, v); chk(tag, v, m_atb[63:32]);
        rd(3'd4, v); chk(tag, v, m_dec);
        chk(tag, {31'd0, dec_irq}, {31'd0, m_pend});
    endtask

    // one clock: inputs applied now (between edges), model stepped, returns at next negedge
    task automatic cyc(input logic t, input logic r, input logic [2:0] s, input logic w,
                       input logic [31:0] d, input logic rl, input logic a);
        logic adv, set;
        tick_en = t; run_en = r; acc_sel = s; acc_wr = w; acc_wdata = d;
        rate_load = rl; dec_ack = a;
        adv = t & r;
        if (w && s == 3'd0)      m_tb[31:0]  = d;
        else if (w && s == 3'd1) m_tb[63:32] = d;
        else if (w && s == 3'd5) m_tb[31:0]  = d & MASK;
        else if (adv)            m_tb = m_tb + 64'd1;
        if (w && s == 3'd2)      m_atb[31:0]  = d;
        else if (w && s == 3'd3) m_atb[63:32] = d;
        else if (adv)            m_atb = m_atb + 64'd1;
        set = 1'b0;
        if (rl) m_dec = 32'hFFFF_FFFF;
        else if (w && s == 3'd4) begin set = d[31] & ~m_dec[31]; m_dec = d; end
        else if (adv) begin set = (m_dec == 32'd0); m_dec = m_dec - 32'd1; end
        m_pend = set | (m_pend & ~a);
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0; acc_wr = 1'b0; rate_load = 1'b0; dec_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [5];
        pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'h7FFF_FFFF;
        pats[3] = 32'h8000_0000; pats[4] = 32'hFFFF_FFFF;
        m_tb = '0; m_atb = '0; m_dec = 32'hFFFF_FFFF; m_pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R7");

        // R1/R5: free counting
        for (int i = 0; i < 40; i++) begin
            cyc(1'b1, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b0);
            read_all("R1");
        end

        // R1/R2: carry across the half boundary from several starting points
        for (int k = 0; k < 8; k++) begin
            cyc(1'b0, 1'b1, 3'd0, 1'b1, 32'hFFFF_FFFF - k, 1'b0, 1'b0);
            read_all("R2");
            cyc(1'b0, 1'b1, 3'd1, 1'b1, 32'h10 + k, 1'b0, 1'b0);
            read_all("R2");
            rd(3'd0, v); chk("R2", v, 32'hFFFF_FFFF - k);
            for (int j = 0; j < 10; j++) begin
                cyc(1'b1, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b0);
                read_all("R1");
            end
        end

        // R3: alternate base written independently
        cyc(1'b0, 1'b1, 3'd2, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 3'd3, 1'b1, 32'h0000_0ABC, 1'b0, 1'b0);
        read_all("R3");
        for (int j = 0; j < 5; j++) begin
            cyc(1'b1, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b0);
            read_all("R3");
        end
        rd(3'd3, v); chk("R3", v, 32'h0000_0ABD);

        // R10: write with tick in the same cycle
        cyc(1'b1, 1'b1, 3'd0, 1'b1, 32'h1234_5678, 1'b0, 1'b0);
        rd(3'd0, v); chk("R10", v, 32'h1234_5678);
        cyc(1'b1, 1'b1, 3'd4, 1'b1, 32'h0000_0100, 1'b0, 1'b0);
        rd(3'd4, v); chk("R10", v, 32'h0000_0100);
        read_all("R10");

        // R4: freeze then resume
        for (int j = 0; j < 10; j++) begin
            cyc(1'b1, 1'b0, 3'd7, 1'b0, '0, 1'b0, 1'b0);
            read_all("R4");
        end
        rd(3'd0, v); chk("R4", v, 32'h1234_5679);
        cyc(1'b1, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b0);
        rd(3'd0, v); chk("R4", v, 32'h1234_567A);

        // R5/R9: wrap through zero, sticky, ack
        cyc(1'b0, 1'b1, 3'd4, 1'b1, 32'd2, 1'b0, 1'b0);
        for (int j = 0; j < 4; j++) begin
            cyc(1'b1, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b0);
            read_all("R5");
        end
        chk("R5", {31'd0, dec_irq}, 32'd1);
        rd(3'd4, v); chk("R5", v, 32'hFFFF_FFFE);
        repeat (3) cyc(1'b0, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b0);
        chk("R9", {31'd0, dec_irq}, 32'd1);
        cyc(1'b0, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b1);
        chk("R9", {31'd0, dec_irq}, 32'd0);
        cyc(1'b0, 1'b1, 3'd4, 1'b1, 32'd0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b1);
        chk("R9", {31'd0, dec_irq}, 32'd1);
        read_all("R9");
        cyc(1'b0, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b1);

        // R6: every pairing of old and new sign patterns
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                cyc(1'b0, 1'b1, 3'd4, 1'b1, pats[a], 1'b0, 1'b0);
                cyc(1'b0, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b1);
                cyc(1'b0, 1'b1, 3'd4, 1'b1, pats[b], 1'b0, 1'b0);
                chk("R6", {31'd0, dec_irq}, {31'd0, pats[b][31] & ~pats[a][31]});
                read_all("R6");
            end
        end

        // R7: rate load parks at all-ones, quietly, even over a write
        cyc(1'b0, 1'b1, 3'd7, 1'b0, '0, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 3'd4, 1'b1, 32'd5, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 3'd4, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        rd(3'd4, v); chk("R7", v, 32'hFFFF_FFFF);
        chk("R7", {31'd0, dec_irq}, 32'd0);
        read_all("R7");

        // R8: compatibility view, one bit at a time
        cyc(1'b0, 1'b1, 3'd1, 1'b1, 32'hCAFE_0001, 1'b0, 1'b0);
        for (int i = 0; i < 32; i++) begin
            cyc(1'b0, 1'b1, 3'd5, 1'b1, (32'd1 << i) | 32'h8000_0041, 1'b0, 1'b0);
            rd(3'd5, v); chk("R8", v, ((32'd1 << i) | 32'h8000_0041) & MASK);
            rd(3'd0, v); chk("R8", v, ((32'd1 << i) | 32'h8000_0041) & MASK);
            rd(3'd1, v); chk("R8", v, 32'hCAFE_0001);
        end
        cyc(1'b0, 1'b1, 3'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        rd(3'd5, v); chk("R8", v, MASK);

        // R11: unused selectors
        for (int s = 6; s < 8; s++) begin
            cyc(1'b0, 1'b1, 3'(s), 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
            rd(3'(s), v); chk("R11", v, 32'd0);
            read_all("R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule